// File: doc/BRIEF.md
# Binary Counter Scanned Display

This block shows a free-running binary count on a four-digit, common-anode, seven-segment display that is driven one digit at a time. Each bit of the count gets its own digit. That digit shows the glyph for 0 or 1. The most significant bit sits on the leftmost digit, and the fourth digit stays dark.

All logic runs in one 5 MHz clock domain, with no derived clocks. Two free-running dividers produce single-cycle enable pulses. The slower pulse steps the count, about every 0.84 s by default. The faster pulse, about every 152.6 Hz, moves the scan to the next digit. Each digit is therefore refreshed at roughly 38 Hz.

A one-hot ring register picks the active digit. A mux selects the count bit that belongs to that digit, and a small decoder turns that bit into segment levels. The divider widths are parameters, so a bench can shrink the time scale.

Top module: `bitcount_scan_display`

## Requirements
- R1: Exactly one bit of `digit_en_n` is low in every cycle. The enables are active low, with bit 3 driving the leftmost digit D1 and bit 0 driving D4.
- R2: The scan tick fires once every 2^SCAN_DIV_W cycles. On each tick the active digit moves D1 → D2 → D3 → D4 → D1. This gives the enable patterns 0111, 1011, 1101 and 1110. Between ticks the selection holds.
- R3: The count advances by one once every 2^COUNT_DIV_W cycles. It steps 000, 001, … 111 and then wraps to 000. Between steps it holds.
- R4: D1 shows count bit 2, D2 shows bit 1 and D3 shows bit 0.
- R5: `seg_n` bit 0 is segment a and bit 6 is segment g, all active low. A 0 is shown as 7'b1000000, which lights a–f. A 1 is shown as 7'b1111001, which lights b and c.
- R6: While D4 is enabled, `seg_n` is 7'b1111111, so every segment is off.
- R7: `dp_n` is always high, so the decimal point stays off.
- R8: A synchronous active-low reset `rst_n` clears the count and both dividers and selects D1. The first scan tick after release comes 2^SCAN_DIV_W cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5 MHz system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| digit_en_n | output | CNT_W+1 | Digit enables, active low, MSB is leftmost digit |
| seg_n | output | 7 | Segments a (bit 0) to g (bit 6), active low |
| dp_n | output | 1 | Decimal point, active low, held off |

## Verification
The embedded properties check several behaviours on every cycle:
- the digit selection is one-hot;
- it rotates by exactly one position on a scan pulse and holds otherwise;
- the count increments modulo eight only on its pulse;
- divider pulses never come on back-to-back cycles;
- the blank slot drives every segment high;
- a digit slot always keeps segments b and c lit and segment g dark.

Some behaviours only the bench scenarios can show:
- which count bit lands on which digit;
- the exact glyph for each bit value;
- the full sequence of enable patterns;
- the wrap from 111 to 000 as seen at the pins;
- that a mid-run reset also restarts the scan divider, which the delay before the first rotation reveals.

// File: rtl/bcsd_pkg.sv
// Package: shared segment type and glyph constants for the scanned display.
// Assumes segment bit 0 = a ... bit 6 = g, all active low.
package bcsd_pkg;
    typedef logic [6:0] seg_t;
    localparam seg_t SEG_BLANK = 7'b1111111;
    localparam seg_t SEG_ZERO  = 7'b1000000;
    localparam seg_t SEG_ONE   = 7'b1111001;
endpackage

// File: rtl/tick_divider.sv
// Module: free-running power-of-two divider that emits a one-cycle enable pulse.
// Assumes W >= 1; the pulse is high while the accumulator holds all ones,
// so the first pulse comes 2^W - 1 cycles after reset release.
module tick_divider #(
    parameter int W = 15
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [W-1:0] acc_q;

    // Advance the accumulator each cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + 1'b1;
    end

    assign tick = &acc_q;

    // R2 R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/bit_counter.sv
// Module: CNT_W-bit binary counter that steps once per enable pulse and wraps.
// Assumes step is a single-cycle pulse in the clk domain.
module bit_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    // Increment on step, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + 1'b1;
    end

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> count == CNT_W'($past(count) + 1'b1));
    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));
    // R8
    count_reset_chk: assert property (@(posedge clk)
        !rst_n |=> count == '0);
endmodule

// File: rtl/digit_ring.sv
// Module: one-hot ring selecting the active digit; MSB is the leftmost digit.
// Assumes advance is a single-cycle pulse; rotation goes MSB toward LSB.
module digit_ring #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    output logic [NUM_SLOTS-1:0] ring
);
    localparam logic [NUM_SLOTS-1:0] RING_INIT = {1'b1, {(NUM_SLOTS-1){1'b0}}};

    // Rotate the active slot one step right on each advance pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       ring <= RING_INIT;
        else if (advance) ring <= {ring[0], ring[NUM_SLOTS-1:1]};
    end

    // R1
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring) == 1);
    // R2
    ring_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> ring == {$past(ring[0]), $past(ring[NUM_SLOTS-1:1])});
    // R2
    ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ring));
    // R8
    ring_reset_chk: assert property (@(posedge clk)
        !rst_n |=> ring == RING_INIT);
endmodule

// File: rtl/glyph_decoder.sv
// Module: maps one bit (or a blank request) to active-low segment levels.
// Assumes blank takes priority over the bit value.
module glyph_decoder
    import bcsd_pkg::*;
(
    input  logic blank,
    input  logic bit_val,
    output seg_t seg_n
);
    // Select the glyph for the current slot.
    always_comb begin
        if (blank)        seg_n = SEG_BLANK;
        else if (bit_val) seg_n = SEG_ONE;
        else              seg_n = SEG_ZERO;
    end
endmodule

// File: rtl/bitcount_scan_display.sv
// Module: top of the scanned display; shows each count bit on its own digit.
// Assumes a single clock domain; dividers make enables rather than clocks.
// The last (rightmost) slot is a blank digit.
module bitcount_scan_display
    import bcsd_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int SCAN_DIV_W  = 15,
    parameter int COUNT_DIV_W = 22
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [CNT_W:0] digit_en_n,
    output logic [6:0]     seg_n,
    output logic           dp_n
);
    localparam int NUM_SLOTS = CNT_W + 1;

    logic                 scan_tick;
    logic                 count_tick;
    logic [CNT_W-1:0]     count;
    logic [NUM_SLOTS-1:0] ring;
    logic                 shown_bit;
    seg_t                 glyph;

    tick_divider #(.W(SCAN_DIV_W)) scan_div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (scan_tick)
    );

    tick_divider #(.W(COUNT_DIV_W)) count_div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (count_tick)
    );

    bit_counter #(.CNT_W(CNT_W)) counter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (count_tick),
        .count (count)
    );

    digit_ring #(.NUM_SLOTS(NUM_SLOTS)) ring_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (scan_tick),
        .ring    (ring)
    );

    // Pick the count bit that belongs to the active digit slot.
    always_comb begin
        shown_bit = |(ring[NUM_SLOTS-1:1] & count);
    end

    glyph_decoder glyph_i (
        .blank   (ring[0]),
        .bit_val (shown_bit),
        .seg_n   (glyph)
    );

    assign digit_en_n = ~ring;
    assign seg_n      = glyph;
    assign dp_n       = 1'b1;

    // R6
    blank_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !digit_en_n[0] |-> seg_n == SEG_BLANK);
    // R5
    digit_glyph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_en_n[0] |-> (seg_n[6] && !seg_n[1] && !seg_n[2]));
endmodule

// File: tb/bitcount_scan_display_tb_top.sv
// Bench: walks a table of enable patterns over two full count cycles, then
// directed tests for reset and its restart of the scan divider.
module bitcount_scan_display_tb_top;
    localparam int SW = 2;   // scan pulse every 4 cycles
    localparam int CW = 4;   // count pulse every 16 cycles
    localparam logic [3:0] EN_TBL [4] = '{4'b0111, 4'b1011, 4'b1101, 4'b1110};
    localparam logic [6:0] G0 = 7'b1000000;
    localparam logic [6:0] G1 = 7'b1111001;
    localparam logic [6:0] GB = 7'b1111111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit_en_n;
    logic [6:0] seg_n;
    logic       dp_n;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    bitcount_scan_display #(.CNT_W(3), .SCAN_DIV_W(SW), .COUNT_DIV_W(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .digit_en_n (digit_en_n),
        .seg_n      (seg_n),
        .dp_n       (dp_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_seg(input int cnt, input int slot);
        if (slot == 3) return GB;
        return ((cnt >> (2 - slot)) & 1) != 0 ? G1 : G0;
    endfunction

    // Check enable, segments and dp for a given count and slot.
    task automatic chk_view(input string tag, input int cnt, input int slot);
        chk({tag, " R1 R2 enables"}, 16'(digit_en_n), 16'(EN_TBL[slot]));
        chk({tag, " R4 R5 R6 segments"}, 16'(seg_n), 16'(exp_seg(cnt, slot)));
        chk({tag, " R7 dp"}, 16'(dp_n), 16'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state: D1 selected, count 0
        chk_view("reset R8", 0, 0);
        // Table walk: two full count cycles, covers R3 wrap 111 -> 000
        for (int idx = 1; idx <= 64; idx++) begin
            repeat (4) @(posedge clk);
            @(negedge clk);
            chk_view("table R3", (idx / 4) % 8, idx % 4);
        end
        // Advance to count 2, slot D3 (n = 296)
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk_view("pre-reset R3", 2, 2);
        // Mid-run synchronous reset
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_view("midrun R8", 0, 0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Divider restarted: no rotation for 3 edges, rotation at the 4th
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_view("divider restart R8", 0, 0);
        @(posedge clk);
        @(negedge clk);
        chk_view("first rotate R2", 0, 1);
        // Count 1 on D3 at n = 25
        repeat (21) @(posedge clk);
        @(negedge clk);
        chk_view("count one R4", 1, 2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule